// File: doc/BRIEF.md
# Operand address and fetch unit

This block sits between instruction decode and execute. It takes a 32-bit instruction word on a start strobe and splits it into its fields. It then forms a base value from the sign-extended 16-bit constant plus an index register, which it reads through a combinational register-file read port. Depending on the two-bit mode field, the unit performs zero, one or two memory reads through a request/valid port. It then returns the second operand, the effective address, the opcode and the first-register number, together with a one-cycle done strobe.

Every mode is indexed. Index register number 0 always contributes zero, whatever R0 holds. Stores and every jump or call opcode need an address rather than a value, so they stop one memory level earlier than loads do. Executing the instruction, writing registers and writing memory happen elsewhere.

Top module: `opfetch_unit`

## Requirements
- R1: The instruction word is decoded with the opcode in bits 31:24, the first register in bits 23:21, the mode in bits 20:19, the index register in bits 18:16 and the constant in bits 15:0. The opcode and first-register outputs carry those fields of the accepted word when done pulses, and a first-register value of 0 is passed through unchanged.
- R2: The base value is the 16-bit constant, sign-extended, plus the index register value (for example, constant 0xFFFF with index value 5 gives 4, and 0x8000 with index 0 gives 0xFFFF8000).
- R3: When the index field is 0, the base uses zero in place of the R0 contents.
- R4: Mode 00 makes no memory read. For a non-destination opcode, both operand and effective address equal the base.
- R5: Mode 01 on a non-destination opcode makes one read at the base. The operand is the returned word and the effective address is the base.
- R6: Mode 10 on a non-destination opcode reads at the base and then at the word returned. The operand is the second returned word and the effective address is the first returned word.
- R7: Destination opcodes are 0x01, 0x20 through 0x2C, and 0x31. For these, the read count is one less than the mode gives, never below zero, and the operand and effective address both equal the last computed address.
- R8: Mode 11 sets the error output together with done and makes no memory read. The error output clears when the next instruction is accepted.
- R9: Done is high for exactly one cycle per accepted instruction. Each memory request is a one-cycle pulse, and the next step waits for the read-valid strobe, however many cycles it takes.
- R10: A start pulse while an instruction is in progress is ignored. The results are those of the instruction in progress, and no extra done follows.
- R11: After reset, done, error and memory request are low, and the operand and effective address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept `instr` when idle |
| instr | input | 32 | Instruction word |
| idx_sel | output | 3 | Register-file read address (index field) |
| idx_data | input | 32 | Register-file read data |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result ready, one-cycle pulse |
| err | output | 1 | Illegal mode flag |
| operand | output | 32 | Second operand |
| eff_addr | output | 32 | Effective address |
| opcode | output | 8 | Opcode field |
| rj | output | 3 | First-register field |

## Verification
The assertions assume three things about the environment. The register-file read data follows `idx_sel` combinationally and stays stable while an instruction is in progress. The memory answers each request with exactly one read-valid pulse, no earlier than the cycle after the request. No read-valid arrives unrequested. The bench drives register values only between instructions, and its memory responder waits one to three cycles after each sampled request before giving a single valid pulse. Read data comes from an address hash, so a read at any address has a known answer.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int INSTR_W = 32;

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  rj;
    logic [1:0]  mode;
    logic [2:0]  ri;
    logic [15:0] konst;
  } instr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } opf_state_e;

  // opcodes whose second operand is an address, not a value
  function automatic logic is_dest(input logic [7:0] op);
    return (op == 8'h01) || (op >= 8'h20 && op <= 8'h2C) || (op == 8'h31);
  endfunction

  // number of memory reads still to issue
  function automatic logic [1:0] mem_levels(input logic [1:0] mode, input logic dest);
    logic [1:0] lv;
    lv = (mode == 2'b11) ? 2'd0 : mode;
    if (dest && lv != 2'd0) lv = lv - 2'd1;
    return lv;
  endfunction
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic [7:0]         op,
  output logic [2:0]         rj,
  output logic [2:0]         ri,
  output logic [15:0]        konst,
  output logic               illegal,
  output logic               dest,
  output logic [1:0]         levels
);
  instr_t f;
  always_comb begin
    f       = instr_t'(word);
    op      = f.op;
    rj      = f.rj;
    ri      = f.ri;
    konst   = f.konst;
    illegal = (f.mode == 2'b11);
    dest    = is_dest(f.op);
    levels  = mem_levels(f.mode, is_dest(f.op));
  end
endmodule

// File: rtl/opf_base_adder.sv
module opf_base_adder #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 16,
  parameter int REG_AW  = 3
) (
  input  logic [CONST_W-1:0] konst,
  input  logic [REG_AW-1:0]  ri,
  input  logic [DATA_W-1:0]  ri_val,
  output logic               ri_zero,
  output logic [DATA_W-1:0]  konst_ext,
  output logic [DATA_W-1:0]  base
);
  localparam int EXT_W = DATA_W - CONST_W;

  function automatic logic [DATA_W-1:0] sext(input logic [CONST_W-1:0] k);
    return {{EXT_W{k[CONST_W-1]}}, k};
  endfunction

  always_comb begin
    ri_zero   = (ri == '0);
    konst_ext = sext(konst);
    base      = konst_ext + (ri_zero ? '0 : ri_val);
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INSTR_W-1:0] instr,
  output logic [INSTR_W-1:0] ir,
  input  logic              illegal,
  input  logic              dest,
  input  logic [1:0]        levels,
  input  logic [DATA_W-1:0] base,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] eff_addr,
  output logic              accept,
  output logic              calc_fire,
  output logic              read_ret,
  output logic              dest_q
);
  opf_state_e state;
  logic [1:0] left_q;
  logic [DATA_W-1:0] addr_q;

  assign accept    = start && (state == ST_IDLE);
  assign calc_fire = (state == ST_CALC);
  assign read_ret  = (state == ST_WAIT) && mem_rvalid;
  assign mem_req   = (state == ST_REQ);
  assign mem_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ir       <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      operand  <= '0;
      eff_addr <= '0;
      dest_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          ir    <= instr;
          err   <= 1'b0;
          state <= ST_CALC;
        end
        ST_CALC: begin
          dest_q <= dest;
          if (illegal || levels == 2'd0) begin
            err      <= illegal;
            done     <= 1'b1;
            operand  <= base;
            eff_addr <= base;
            state    <= ST_IDLE;
          end else begin
            addr_q <= base;
            left_q <= levels;
            state  <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          if (left_q == 2'd1) begin
            operand  <= mem_rdata;
            eff_addr <= dest_q ? mem_rdata : addr_q;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            addr_q <= mem_rdata;
            left_q <= left_q - 2'd1;
            state  <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
  import opf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 16,
  parameter int REG_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr,
  output logic [REG_AW-1:0] idx_sel,
  input  logic [DATA_W-1:0] idx_data,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] eff_addr,
  output logic [7:0]        opcode,
  output logic [2:0]        rj
);
  logic [INSTR_W-1:0] ir;
  logic [7:0]  d_op;
  logic [2:0]  d_rj, d_ri;
  logic [15:0] d_konst;
  logic        d_illegal, d_dest;
  logic [1:0]  d_levels;
  logic        ri_zero;
  logic [DATA_W-1:0] konst_ext, base;
  logic        accept, calc_fire, read_ret, dest_q;

  opf_decode u_dec (
    .word(ir), .op(d_op), .rj(d_rj), .ri(d_ri), .konst(d_konst),
    .illegal(d_illegal), .dest(d_dest), .levels(d_levels)
  );

  opf_base_adder #(.DATA_W(DATA_W), .CONST_W(CONST_W), .REG_AW(REG_AW)) u_add (
    .konst(d_konst[CONST_W-1:0]), .ri(d_ri[REG_AW-1:0]), .ri_val(idx_data),
    .ri_zero(ri_zero), .konst_ext(konst_ext), .base(base)
  );

  opf_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .ir(ir),
    .illegal(d_illegal), .dest(d_dest), .levels(d_levels), .base(base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .err(err), .operand(operand),
    .eff_addr(eff_addr), .accept(accept), .calc_fire(calc_fire),
    .read_ret(read_ret), .dest_q(dest_q)
  );

  assign idx_sel = d_ri[REG_AW-1:0];
  assign opcode  = d_op;
  assign rj      = d_rj;
endmodule

// File: rtl/opfetch_unit_checker.sv
module opfetch_unit_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              calc_fire,
  input logic              read_ret,
  input logic              d_illegal,
  input logic              d_dest,
  input logic [1:0]        d_levels,
  input logic              ri_zero,
  input logic [DATA_W-1:0] konst_ext,
  input logic [DATA_W-1:0] base,
  input logic              mem_req,
  input logic              done,
  input logic              err
);
  logic [2:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= '0;
    else if (accept) rd_cnt <= '0;
    else if (mem_req) rd_cnt <= rd_cnt + 3'd1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_no_ret_while_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !read_ret);
  assert_illegal_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_fire && d_illegal) |=> (done && err && !mem_req));
  assert_imm_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_fire && d_levels == 2'd0) |=> (done && !mem_req));
  assert_index_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_fire && ri_zero) |-> (base == konst_ext));
  assert_two_reads_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rd_cnt < 3'd2));
  assert_dest_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rd_cnt != 3'd0) |-> !d_dest);
  assert_no_err_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !err);
endmodule

bind opfetch_unit opfetch_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .calc_fire(calc_fire),
  .read_ret(read_ret), .d_illegal(d_illegal), .d_dest(d_dest),
  .d_levels(d_levels), .ri_zero(ri_zero), .konst_ext(konst_ext),
  .base(base), .mem_req(mem_req), .done(done), .err(err)
);

// File: tb/opfetch_unit_test.sv
module opfetch_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0]  idx_sel;
  logic [31:0] idx_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, err;
  logic [31:0] operand, eff_addr;
  logic [7:0]  opcode;
  logic [2:0]  rj;

  logic [31:0] regs [8];
  int checks = 0;
  int errors = 0;
  int reads = 0;
  int done_seen = 0;

  always #5 clk = ~clk;

  assign idx_data = regs[idx_sel];

  opfetch_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .idx_sel(idx_sel), .idx_data(idx_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .err(err), .operand(operand), .eff_addr(eff_addr),
    .opcode(opcode), .rj(rj)
  );

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) + 32'h0123_4567;
  endfunction

  function automatic bit dest_op(input logic [7:0] op);
    return op == 8'h01 || op == 8'h31 || (op >= 8'h20 && op <= 8'h2C);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: one valid pulse, 1..3 cycles after each request
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        int n;
        a = mem_addr;
        n = $urandom % 3;
        repeat (n) @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = mem_fn(a);
        reads++;
      end
    end
  end

  always @(posedge clk) if (done) done_seen++;

  task automatic run(input logic [31:0] w, input bit restart_mid, input string tag);
    logic [7:0] op;
    logic [1:0] mode;
    int lv, exp_reads, t;
    logic [31:0] b, opnd, ea, w1;
    bit d;
    op = w[31:24]; mode = w[20:19];
    b = {{16{w[15]}}, w[15:0]} + ((w[18:16] == 3'd0) ? 32'd0 : regs[w[18:16]]);
    d = dest_op(op);
    lv = (mode == 2'b11) ? 0 : int'(mode);
    if (d && lv > 0) lv--;
    exp_reads = lv;
    if (lv == 0) begin opnd = b; ea = b; end
    else if (lv == 1) begin opnd = mem_fn(b); ea = d ? opnd : b; end
    else begin w1 = mem_fn(b); opnd = mem_fn(w1); ea = w1; end

    @(negedge clk);
    reads = 0; done_seen = 0;
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin
      if (restart_mid && t == 1) begin
        instr = ~w; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk); t++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R9", {tag, " done"}, {31'd0, done}, 32'd1);
    if (mode == 2'b11) begin
      chk(err === 1'b1, "R8", {tag, " err"}, {31'd0, err}, 32'd1);
      chk(reads == 0, "R8", {tag, " reads"}, reads, 0);
    end else begin
      chk(err === 1'b0, "R8", {tag, " err low"}, {31'd0, err}, 32'd0);
      chk(operand === opnd, d ? "R7" : (mode == 0 ? "R4" : (mode == 1 ? "R5" : "R6")),
          {tag, " operand"}, operand, opnd);
      chk(eff_addr === ea, "R2", {tag, " eff_addr"}, eff_addr, ea);
      chk(reads == exp_reads, d ? "R7" : "R6", {tag, " reads"}, reads, exp_reads);
    end
    chk(opcode === op, "R1", {tag, " opcode"}, {24'd0, opcode}, {24'd0, op});
    chk(rj === w[23:21], "R1", {tag, " rj"}, {29'd0, rj}, {29'd0, w[23:21]});
    @(negedge clk);
    chk(done === 1'b0, "R9", {tag, " done width"}, {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chk(done_seen == 1, restart_mid ? "R10" : "R9", {tag, " done count"}, done_seen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) regs[i] = $urandom;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R11", "reset ctl",
        {29'd0, done, err, mem_req}, 32'd0);
    chk(operand === 32'd0 && eff_addr === 32'd0, "R11", "reset data", operand ^ eff_addr, 32'd0);
    rst_n = 1'b1;

    // directed: R2 negative constant, R3 zero index with nonzero R0
    regs[0] = 32'hDEAD_BEEF; regs[3] = 32'd5;
    run({8'h02, 3'd1, 2'b00, 3'd3, 16'hFFFF}, 1'b0, "R2 neg const");
    run({8'h02, 3'd0, 2'b00, 3'd0, 16'h8000}, 1'b0, "R3 r0 index");
    run({8'h02, 3'd0, 2'b01, 3'd0, 16'h0010}, 1'b0, "R5 direct");
    run({8'h02, 3'd2, 2'b10, 3'd3, 16'h0100}, 1'b0, "R6 indirect");
    run({8'h01, 3'd4, 2'b10, 3'd3, 16'h0020}, 1'b0, "R7 store ind");
    run({8'h20, 3'd0, 2'b01, 3'd0, 16'h0040}, 1'b0, "R7 jump dir");
    run({8'h31, 3'd6, 2'b00, 3'd2, 16'h0004}, 1'b0, "R7 call imm");
    run({8'h11, 3'd1, 2'b11, 3'd1, 16'h0001}, 1'b0, "R8 illegal");
    run({8'h02, 3'd1, 2'b00, 3'd1, 16'h0007}, 1'b0, "R8 err clears");
    run({8'h02, 3'd5, 2'b10, 3'd4, 16'h1234}, 1'b1, "R10 restart");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      for (int k = 0; k < 8; k++) regs[k] = $urandom;
      w = $urandom;
      if ((i % 3) == 0) begin
        int pick;
        pick = $urandom % 15;
        w[31:24] = (pick == 0) ? 8'h01 : (pick == 1) ? 8'h31 : 8'(8'h20 + pick - 2);
      end
      run(w, (i % 17) == 0, "rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule